// File: doc/BRIEF.md
# Eight-Bit ALU With Condition Flags

This block is the arithmetic/logic datapath of a small accumulator-style processor. Two operand words, a carry input and a three-bit function code produce a result word in the same cycle. Three status outputs go with the result: an unsigned carry, a signed overflow and a zero indication. A flag register keeps the three status bits when the microcode raises its load strobe. The register clears on a synchronous reset.

The function set has eight entries: clear, two subtract orders, add, and three bitwise operations, plus preset. There is no complement function and no shifter. A one's complement is an XOR with an all-ones operand. A left shift is an operand added to itself. The zero status comes from the result word itself for every function, so a decrement loop can branch on it without an extra compare.

Top module: `alu8_core`

## Requirements
- R1: The function code on `func_sel` selects the result: 0 gives all zeros, 1 gives B minus A, 2 gives A minus B, 3 gives A plus B, 4 gives A XOR B, 5 gives A OR B, 6 gives A AND B, 7 gives all ones.
- R2: For code 3 the result is (A + B + carry_in) modulo 2^W, and `carry_out` is the carry out of the top bit.
- R3: For codes 1 and 2 the result is minuend + NOT(subtrahend) + carry_in. With carry_in = 1 this is the true difference, and `carry_out` = 1 means no borrow occurred.
- R4: For codes 1 to 3, `ovf_out` is 1 exactly when the two's-complement result is outside the signed range (-128 to +127 at W = 8). For codes 0, 4, 5, 6 and 7 it is 0.
- R5: `zero_out` is 1 exactly when every result bit is 0, for every function code.
- R6: For codes 0, 4, 5, 6 and 7, `carry_out` is 0.
- R7: At a rising clock edge with `flag_ld` = 1, `flag_c`, `flag_v` and `flag_z` take the values of `carry_out`, `ovf_out` and `zero_out`. With `flag_ld` = 0 they hold their values.
- R8: At a rising clock edge with `rst` = 1, all three flags become 0. Reset takes priority over `flag_ld`.
- R9: XOR with 8'hFF yields the one's complement, and adding an operand to itself with carry_in = 0 yields the operand shifted left by one, with the old top bit in `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| carry_in | input | 1 | Carry input to the adder |
| func_sel | input | 3 | Function code |
| flag_ld | input | 1 | Flag register load strobe |
| result | output | 8 | Result word |
| carry_out | output | 1 | Unsigned carry, or no-borrow for subtracts |
| ovf_out | output | 1 | Signed overflow |
| zero_out | output | 1 | Result is all zeros |
| flag_c | output | 1 | Registered carry |
| flag_v | output | 1 | Registered overflow |
| flag_z | output | 1 | Registered zero |

## Verification
On every cycle the assertions check four things. Overflow must agree with a sign-bit rule that is independent of the carry chain. Carry and overflow must stay low on non-arithmetic codes. Zero must track the result. The flag register must load, hold and reset as specified. Only the bench scenarios show that each code produces the right result word, and that the carry and no-borrow values are correct at the wrap-around points. The same holds for the complement and shift idioms and for reset taking priority over a load.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [2:0] {
      FN_CLEAR  = 3'd0,
      FN_BSUBA  = 3'd1,
      FN_ASUBB  = 3'd2,
      FN_ADD    = 3'd3,
      FN_XOR    = 3'd4,
      FN_OR     = 3'd5,
      FN_AND    = 3'd6,
      FN_PRESET = 3'd7
   } alu_fn_e;

   localparam int FN_BITS = 3;

   function automatic logic fn_is_arith(input alu_fn_e fn);
      return (fn == FN_BSUBA) || (fn == FN_ASUBB) || (fn == FN_ADD);
   endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         cin,
   input  alu_fn_e      fn,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         c_msb
);
   localparam int LOW = W - 1;

   logic [W-1:0] x_op;
   logic [W-1:0] y_op;

   // operand steering: subtracts add the inverted subtrahend
   always_comb begin
      unique case (fn)
         FN_BSUBA: begin x_op = op_b; y_op = ~op_a; end
         FN_ASUBB: begin x_op = op_a; y_op = ~op_b; end
         default:  begin x_op = op_a; y_op = op_b;  end
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cc;
         assign cc[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = x_op[i] ^ y_op[i] ^ cc[i];
            assign cc[i+1] = (x_op[i] & y_op[i]) | (cc[i] & (x_op[i] ^ y_op[i]));
         end
         assign c_msb = cc[W-1];
         assign cout  = cc[W];
      end else begin : g_split
         logic [LOW:0] low_sum;
         logic [1:0]   top_sum;
         assign low_sum = {1'b0, x_op[LOW-1:0]} + {1'b0, y_op[LOW-1:0]} + {{LOW{1'b0}}, cin};
         assign c_msb   = low_sum[LOW];
         assign top_sum = {1'b0, x_op[W-1]} + {1'b0, y_op[W-1]} + {1'b0, c_msb};
         assign sum     = {top_sum[0], low_sum[LOW-1:0]};
         assign cout    = top_sum[1];
      end
   endgenerate
endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  alu_fn_e      fn,
   output logic [W-1:0] res
);
   always_comb begin
      unique case (fn)
         FN_XOR:    res = op_a ^ op_b;
         FN_OR:     res = op_a | op_b;
         FN_AND:    res = op_a & op_b;
         FN_PRESET: res = {W{1'b1}};
         default:   res = '0;
      endcase
   end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg (
   input  logic clk,
   input  logic rst,
   input  logic ld,
   input  logic c_d,
   input  logic v_d,
   input  logic z_d,
   output logic c_q,
   output logic v_q,
   output logic z_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         c_q <= 1'b0;
         v_q <= 1'b0;
         z_q <= 1'b0;
      end else if (ld) begin
         c_q <= c_d;
         v_q <= v_d;
         z_q <= z_d;
      end
   end

   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      !ld |=> ($stable(c_q) && $stable(v_q) && $stable(z_q)));
   a_r7_load: assert property (@(posedge clk) disable iff (rst)
      ld |=> (c_q == $past(c_d) && v_q == $past(v_d) && z_q == $past(z_d)));
   a_r8_reset: assert property (@(posedge clk)
      rst |=> (!c_q && !v_q && !z_q));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [W-1:0]       a_in,
   input  logic [W-1:0]       b_in,
   input  logic               carry_in,
   input  logic [FN_BITS-1:0] func_sel,
   input  logic               flag_ld,
   output logic [W-1:0]       result,
   output logic               carry_out,
   output logic               ovf_out,
   output logic               zero_out,
   output logic               flag_c,
   output logic               flag_v,
   output logic               flag_z
);
   generate
      if (W < 2) begin : g_bad_width
         $error("alu8_core: W must be at least 2");
      end
   endgenerate

   alu_fn_e      fn;
   logic [W-1:0] arith_sum;
   logic [W-1:0] logic_res;
   logic         arith_cout;
   logic         arith_cmsb;
   logic         arith_sel;

   assign fn        = alu_fn_e'(func_sel);
   assign arith_sel = fn_is_arith(fn);

   alu8_arith #(.W(W), .RIPPLE(RIPPLE)) u_arith (
      .op_a (a_in),
      .op_b (b_in),
      .cin  (carry_in),
      .fn   (fn),
      .sum  (arith_sum),
      .cout (arith_cout),
      .c_msb(arith_cmsb)
   );

   alu8_logic_unit #(.W(W)) u_logic (
      .op_a(a_in),
      .op_b(b_in),
      .fn  (fn),
      .res (logic_res)
   );

   assign result    = arith_sel ? arith_sum : logic_res;
   assign carry_out = arith_sel & arith_cout;
   assign ovf_out   = arith_sel & (arith_cout ^ arith_cmsb);
   assign zero_out  = ~|result;

   alu8_flag_reg u_flags (
      .clk(clk),
      .rst(rst),
      .ld (flag_ld),
      .c_d(carry_out),
      .v_d(ovf_out),
      .z_d(zero_out),
      .c_q(flag_c),
      .v_q(flag_v),
      .z_q(flag_z)
   );

   // signed overflow by sign rule, independent of the carry chain
   a_r4_add_ovf: assert property (@(posedge clk) disable iff (rst)
      (fn == FN_ADD) |-> ovf_out == ((a_in[W-1] == b_in[W-1]) && (result[W-1] != a_in[W-1])));
   a_r4_asub_ovf: assert property (@(posedge clk) disable iff (rst)
      (fn == FN_ASUBB) |-> ovf_out == ((a_in[W-1] != b_in[W-1]) && (result[W-1] != a_in[W-1])));
   a_r4_bsub_ovf: assert property (@(posedge clk) disable iff (rst)
      (fn == FN_BSUBA) |-> ovf_out == ((b_in[W-1] != a_in[W-1]) && (result[W-1] != b_in[W-1])));
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
      !arith_sel |-> !ovf_out);
   a_r6_no_carry: assert property (@(posedge clk) disable iff (rst)
      !arith_sel |-> !carry_out);
   a_r5_zero: assert property (@(posedge clk) disable iff (rst)
      zero_out == ($countones(result) == 0));
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] a_in, b_in;
   logic       carry_in;
   logic [2:0] func_sel;
   logic       flag_ld;
   logic [7:0] result;
   logic       carry_out, ovf_out, zero_out;
   logic       flag_c, flag_v, flag_z;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   alu8_core u0 (
      .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
      .func_sel(func_sel), .flag_ld(flag_ld), .result(result),
      .carry_out(carry_out), .ovf_out(ovf_out), .zero_out(zero_out),
      .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
   );

   // {sel, cin, a, b, result, c, v, z}
   localparam int NV = 18;
   localparam logic [30:0] VEC [NV] = '{
      {3'd3, 1'b0, 8'h01, 8'h02, 8'h03, 1'b0, 1'b0, 1'b0}, // R2
      {3'd3, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1, 1'b0}, // R4
      {3'd3, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1}, // R2 R5
      {3'd3, 1'b1, 8'h80, 8'h80, 8'h01, 1'b1, 1'b1, 1'b0}, // R2 R4
      {3'd2, 1'b1, 8'h05, 8'h03, 8'h02, 1'b1, 1'b0, 1'b0}, // R3
      {3'd2, 1'b1, 8'h03, 8'h05, 8'hFE, 1'b0, 1'b0, 1'b0}, // R3 borrow
      {3'd2, 1'b1, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1, 1'b0}, // R4
      {3'd1, 1'b1, 8'h05, 8'h05, 8'h00, 1'b1, 1'b0, 1'b1}, // R3 R5
      {3'd1, 1'b1, 8'hFF, 8'h7F, 8'h80, 1'b0, 1'b1, 1'b0}, // R4
      {3'd2, 1'b0, 8'h05, 8'h03, 8'h01, 1'b1, 1'b0, 1'b0}, // R3 cin 0
      {3'd4, 1'b1, 8'hA5, 8'hFF, 8'h5A, 1'b0, 1'b0, 1'b0}, // R9 complement
      {3'd5, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}, // R5 R6
      {3'd6, 1'b0, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b0, 1'b1}, // R1 R5
      {3'd0, 1'b1, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1}, // R1 R6
      {3'd7, 1'b1, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0}, // R1 R6
      {3'd3, 1'b0, 8'hC1, 8'hC1, 8'h82, 1'b1, 1'b0, 1'b0}, // R9 shift
      {3'd5, 1'b0, 8'h0C, 8'h30, 8'h3C, 1'b0, 1'b0, 1'b0}, // R1
      {3'd6, 1'b0, 8'hFF, 8'h3C, 8'h3C, 1'b0, 1'b0, 1'b0}  // R1
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] s, input logic ci, input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      func_sel = s; carry_in = ci; a_in = a; b_in = b;
      #1;
   endtask

   initial begin : watchdog
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      rst = 1'b1; flag_ld = 1'b1;
      a_in = 8'h00; b_in = 8'h01; carry_in = 1'b0; func_sel = 3'd3;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R8 reset", {29'd0, flag_c, flag_v, flag_z}, 32'd0);
      rst = 1'b0; flag_ld = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][30:28], VEC[i][27], VEC[i][26:19], VEC[i][18:11]);
         chk("R1 result", {24'd0, result}, {24'd0, VEC[i][10:3]});
         chk("R2 R3 R6 carry", {31'd0, carry_out}, {31'd0, VEC[i][2]});
         chk("R4 overflow", {31'd0, ovf_out}, {31'd0, VEC[i][1]});
         chk("R5 zero", {31'd0, zero_out}, {31'd0, VEC[i][0]});
      end

      // R7 load: FF + 01 gives carry and zero
      drive(3'd3, 1'b0, 8'hFF, 8'h01);
      flag_ld = 1'b1;
      @(negedge clk);
      chk("R7 load", {29'd0, flag_c, flag_v, flag_z}, 32'b101);
      // R7 hold: overflowing add with load low leaves flags alone
      flag_ld = 1'b0;
      a_in = 8'h7F;
      repeat (2) @(negedge clk);
      chk("R7 hold", {29'd0, flag_c, flag_v, flag_z}, 32'b101);
      // R7 load of overflow only
      flag_ld = 1'b1;
      @(negedge clk);
      chk("R7 load v", {29'd0, flag_c, flag_v, flag_z}, 32'b010);
      // R8 reset wins over load
      func_sel = 3'd3; a_in = 8'hFF; b_in = 8'h01;
      rst = 1'b1;
      @(negedge clk);
      chk("R8 priority", {29'd0, flag_c, flag_v, flag_z}, 32'd0);
      rst = 1'b0; flag_ld = 1'b0;

      // R9 shift of 0x80 loses top bit into carry
      drive(3'd3, 1'b0, 8'h80, 8'h80);
      chk("R9 shift", {23'd0, carry_out, result}, {23'd0, 1'b1, 8'h00});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule